// File: doc/BRIEF.md
# Wake-Timed Serial ADC Sampling Controller

This block paces a serial ADC that converts without pause whenever its chip-select and serial clock are toggled, and that reports neither a single-shot mode nor a conversion-done flag. The only way to pin a sample instant to a known time is to park the converter in power-down and then wake it on purpose. The controller does exactly that. It keeps the converter asleep until a start request arrives. It then runs one long wake frame, sits out a fixed warm-up count and runs back-to-back conversion frames. The result of each frame is shifted in and marked with a one-cycle valid pulse that the block makes itself.

A run ends after a programmed number of results, or after a stop request. Either way the controller sends one short frame that drops the converter back into power-down and then idles. Because every run starts from the same sleeping state, the first result of a run always arrives a fixed number of clock cycles after the start request. Equivalent-time acquisition relies on that fixed offset.

Top module: `wake_adc_ctrl`

## Requirements
- R1: While reset is high, and for the first cycles after it, busy_o is high. After reset the block sends one power-down frame and then idles with cs_n_o=1, sclk_o=1 and busy_o=0.
- R2: A power-down frame holds chip-select low for exactly SLEEP_FALLS (3) serial-clock falling edges. It raises it before a 4th falling edge. That point lies after the 2nd and before the 10th falling edge.
- R3: A start_i pulse while idle produces a wake frame that keeps chip-select low for FRAME_FALLS (16) falling edges, which is more than 10.
- R4: After the wake frame the block waits WARM_CYC clock cycles (800 ns at the default) before the first conversion frame. No frame that begins inside that window is reported with dout_valid_o.
- R5: A conversion frame keeps chip-select low for 16 falling edges. The serial clock period is 2*DIV clock cycles. Between frames chip-select stays high for at least one serial-clock period.
- R6: Serial data is sampled at each falling edge, most significant bit first. dout_o is frame bits 14 down to 7, where bit 15 is the first bit sampled. dout_valid_o is a one-cycle pulse after each conversion frame, raised only after chip-select has gone high.
- R7: With num_samples_i nonzero when start_i is taken, exactly that many results are delivered, then a power-down frame follows and the block idles. Zero means the run continues until a stop.
- R8: stop_i during conversion lets the current frame finish and report its result, then the block powers down and idles. stop_i during the wake frame or warm-up yields no result.
- R9: start_i outside the idle state is ignored: no extra wake frame and no change of the sample count.
- R10: busy_o is high in every state except idle, including the power-down frame, the wake frame and warm-up.
- R11: The number of cycles from an accepted start_i to the first dout_valid_o is the same for every run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Request to wake the converter and begin a run |
| stop_i | input | 1 | Request to end the current run |
| num_samples_i | input | CNT_W | Results per run, 0 = until stop |
| sdata_i | input | 1 | Serial data from the converter |
| cs_n_o | output | 1 | Active-low chip-select to the converter |
| sclk_o | output | 1 | Serial clock to the converter, idles high |
| dout_o | output | RES_W | Last captured result |
| dout_valid_o | output | 1 | One-cycle pulse when dout_o is new |
| busy_o | output | 1 | High whenever the block is not idle |

## Verification
The bench builds the block with DIV=2, which gives a 16 ns serial clock, and WARM_CYC=200, which is exactly 800 ns at the bench clock. At these values the converter model can check the warm-up bound in real time, and a whole run of wake, warm-up and several frames is a few hundred cycles long. The short divider also lets edge spacing, the power-down window and several start/stop placements be covered within a compact run. The 8-bit sample count is large enough for both limited and unlimited runs.

// File: rtl/wadc_pkg.sv
package wadc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE_PD,
        ST_WAKE,
        ST_WARM,
        ST_CONV,
        ST_SLEEP
    } wadc_state_e;

    typedef struct packed {
        logic go;
        logic short_frame;
        logic emit;
    } wadc_frame_ctl_t;

    // half-slot index of the last slot with chip-select low
    function automatic int cs_low_last(input int falls);
        return 2 * falls;
    endfunction

    // half-slot index that closes a frame (one sclk period of CS high)
    function automatic int frame_end_slot(input int falls);
        return 2 * falls + 2;
    endfunction

endpackage

// File: rtl/wadc_frame_gen.sv
module wadc_frame_gen #(
    parameter int DIV         = 2,
    parameter int FALLS_LONG  = 16,
    parameter int FALLS_SHORT = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic go_i,
    input  logic short_i,
    output logic cs_n_o,
    output logic sclk_o,
    output logic sample_o,
    output logic done_o
);
    import wadc_pkg::*;

    localparam int HW = $clog2(frame_end_slot(FALLS_LONG) + 1);
    localparam int DW = $clog2(DIV + 1);

    logic          active;
    logic          short_q;
    logic [HW-1:0] slot;
    logic [DW-1:0] dcnt;
    logic [HW-1:0] low_last;
    logic [HW-1:0] end_slot;
    logic          tick;

    assign low_last = short_q ? HW'(cs_low_last(FALLS_SHORT))
                              : HW'(cs_low_last(FALLS_LONG));
    assign end_slot = low_last + HW'(2);
    assign tick     = active && (dcnt == DW'(DIV - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            active  <= 1'b0;
            short_q <= 1'b0;
            slot    <= '0;
            dcnt    <= '0;
        end else if (!active) begin
            if (go_i) begin
                active  <= 1'b1;
                short_q <= short_i;
                slot    <= '0;
                dcnt    <= '0;
            end
        end else if (tick) begin
            dcnt <= '0;
            if (slot == end_slot) begin
                active <= 1'b0;
            end else begin
                slot <= slot + 1'b1;
            end
        end else begin
            dcnt <= dcnt + 1'b1;
        end
    end

    assign cs_n_o   = !(active && (slot <= low_last));
    assign sclk_o   = !(active && slot[0] && (slot < low_last));
    assign sample_o = tick && !slot[0] && (slot < low_last - HW'(1));
    assign done_o   = tick && (slot == end_slot);

endmodule

// File: rtl/wadc_shift_cap.sv
module wadc_shift_cap #(
    parameter int RES_HI = 14,
    parameter int RES_W  = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sample_i,
    input  logic             sdata_i,
    input  logic             done_i,
    input  logic             emit_i,
    output logic [RES_W-1:0] dout_o,
    output logic             valid_o
);
    localparam int SW = RES_HI + 1;

    logic [SW-1:0] shreg;

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg   <= '0;
            dout_o  <= '0;
            valid_o <= 1'b0;
        end else begin
            if (sample_i) begin
                shreg <= {shreg[SW-2:0], sdata_i};
            end
            valid_o <= done_i && emit_i;
            if (done_i && emit_i) begin
                dout_o <= shreg[RES_HI -: RES_W];
            end
        end
    end

endmodule

// File: rtl/wadc_warm_timer.sv
module wadc_warm_timer #(
    parameter int WARM_CYC = 200
) (
    input  logic clk,
    input  logic rst,
    input  logic load_i,
    output logic expired_o
);
    localparam int TW = $clog2(WARM_CYC + 1);

    logic [TW-1:0] cnt;
    logic          running;

    assign expired_o = running && (cnt == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt     <= '0;
            running <= 1'b0;
        end else if (load_i) begin
            cnt     <= TW'(WARM_CYC - 1);
            running <= 1'b1;
        end else if (running) begin
            if (cnt == '0) begin
                running <= 1'b0;
            end else begin
                cnt <= cnt - 1'b1;
            end
        end
    end

endmodule

// File: rtl/wake_adc_ctrl.sv
module wake_adc_ctrl #(
    parameter int DIV         = 2,
    parameter int WARM_CYC    = 200,
    parameter int CNT_W       = 8,
    parameter int RES_W       = 8,
    parameter int RES_HI      = 14,
    parameter int FRAME_FALLS = 16,
    parameter int SLEEP_FALLS = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic             stop_i,
    input  logic [CNT_W-1:0] num_samples_i,
    input  logic             sdata_i,
    output logic             cs_n_o,
    output logic             sclk_o,
    output logic [RES_W-1:0] dout_o,
    output logic             dout_valid_o,
    output logic             busy_o
);
    import wadc_pkg::*;

    wadc_state_e     state;
    wadc_frame_ctl_t fctl;
    logic            stop_pend;
    logic [CNT_W-1:0] n_target;
    logic [CNT_W-1:0] n_done;
    logic [CNT_W-1:0] n_next;
    logic            f_sample;
    logic            f_done;
    logic            warm_load;
    logic            warm_exp;
    logic            halt_req;

    assign fctl.go          = (state == ST_WAKE) || (state == ST_CONV) || (state == ST_SLEEP);
    assign fctl.short_frame = (state == ST_SLEEP);
    assign fctl.emit        = (state == ST_CONV);
    assign warm_load        = (state == ST_WAKE) && f_done;
    assign n_next           = n_done + 1'b1;
    assign halt_req         = stop_pend || stop_i;
    assign busy_o           = (state != ST_IDLE_PD);

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_SLEEP;
            stop_pend <= 1'b0;
            n_target  <= '0;
            n_done    <= '0;
        end else begin
            case (state)
                ST_IDLE_PD: begin
                    stop_pend <= 1'b0;
                    if (start_i) begin
                        state    <= ST_WAKE;
                        n_target <= num_samples_i;
                        n_done   <= '0;
                    end
                end
                ST_WAKE: begin
                    if (stop_i) stop_pend <= 1'b1;
                    if (f_done) state <= ST_WARM;
                end
                ST_WARM: begin
                    if (stop_i) stop_pend <= 1'b1;
                    if (warm_exp) state <= halt_req ? ST_SLEEP : ST_CONV;
                end
                ST_CONV: begin
                    if (stop_i) stop_pend <= 1'b1;
                    if (f_done) begin
                        n_done <= n_next;
                        if (halt_req || ((n_target != '0) && (n_next == n_target))) begin
                            state <= ST_SLEEP;
                        end
                    end
                end
                ST_SLEEP: begin
                    stop_pend <= 1'b0;
                    if (f_done) state <= ST_IDLE_PD;
                end
                default: state <= ST_SLEEP;
            endcase
        end
    end

    wadc_frame_gen #(
        .DIV(DIV), .FALLS_LONG(FRAME_FALLS), .FALLS_SHORT(SLEEP_FALLS)
    ) frame_i (
        .clk(clk), .rst(rst), .go_i(fctl.go), .short_i(fctl.short_frame),
        .cs_n_o(cs_n_o), .sclk_o(sclk_o), .sample_o(f_sample), .done_o(f_done)
    );

    wadc_warm_timer #(.WARM_CYC(WARM_CYC)) warm_i (
        .clk(clk), .rst(rst), .load_i(warm_load), .expired_o(warm_exp)
    );

    wadc_shift_cap #(.RES_HI(RES_HI), .RES_W(RES_W)) cap_i (
        .clk(clk), .rst(rst), .sample_i(f_sample), .sdata_i(sdata_i),
        .done_i(f_done), .emit_i(fctl.emit), .dout_o(dout_o), .valid_o(dout_valid_o)
    );

endmodule

// File: rtl/wadc_checker.sv
module wadc_checker (
    input logic clk,
    input logic rst,
    input logic start_i,
    input logic cs_n_o,
    input logic sclk_o,
    input logic dout_valid_o,
    input logic busy_o
);
    AST_IDLE_PARKED: assert property (@(posedge clk) disable iff (rst)
        !busy_o |-> (cs_n_o && sclk_o)); // R1

    AST_SCLK_IN_FRAME: assert property (@(posedge clk) disable iff (rst)
        !sclk_o |-> !cs_n_o); // R5

    AST_VALID_PULSE: assert property (@(posedge clk) disable iff (rst)
        dout_valid_o |=> !dout_valid_o); // R6

    AST_VALID_AFTER_CS: assert property (@(posedge clk) disable iff (rst)
        dout_valid_o |-> cs_n_o); // R6

    AST_BUSY_FROM_START: assert property (@(posedge clk) disable iff (rst)
        $rose(busy_o) |-> $past(start_i)); // R9

    AST_BUSY_IN_FRAME: assert property (@(posedge clk) disable iff (rst)
        !cs_n_o |-> busy_o); // R10
endmodule

bind wake_adc_ctrl wadc_checker chk_i (
    .clk(clk), .rst(rst), .start_i(start_i), .cs_n_o(cs_n_o),
    .sclk_o(sclk_o), .dout_valid_o(dout_valid_o), .busy_o(busy_o)
);

// File: tb/wake_adc_ctrl_tb_top.sv
`timescale 1ns/1ps
module wake_adc_ctrl_tb_top;
    localparam int DIV = 2;
    localparam int WARM_CYC = 200;
    localparam int CNT_W = 8;
    localparam int RES_W = 8;
    localparam time TCLK = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start_i = 1'b0;
    logic stop_i = 1'b0;
    logic [CNT_W-1:0] num_samples_i = '0;
    logic sdata_i = 1'b0;
    logic cs_n_o, sclk_o, dout_valid_o, busy_o;
    logic [RES_W-1:0] dout_o;

    always #(TCLK/2) clk = ~clk;

    wake_adc_ctrl #(.DIV(DIV), .WARM_CYC(WARM_CYC), .CNT_W(CNT_W), .RES_W(RES_W)) dut_i (
        .clk(clk), .rst(rst), .start_i(start_i), .stop_i(stop_i),
        .num_samples_i(num_samples_i), .sdata_i(sdata_i), .cs_n_o(cs_n_o),
        .sclk_o(sclk_o), .dout_o(dout_o), .dout_valid_o(dout_valid_o), .busy_o(busy_o)
    );

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // ---------------- converter model ----------------
    bit   mdl_en = 0;
    bit   adc_down = 0;
    bit   frame_ok = 0;
    int   falls = 0;
    time  wake_t = 0;
    time  last_fall = 0;
    time  last_cs_rise = 0;
    int   wake_cnt = 0, last_pd_falls = 0, last_wake_falls = 0;
    int   bad_window = 0, warm_viol = 0, per_viol = 0, gap_viol = 0, conv_bad = 0;
    logic [15:0] word = '0;
    logic [7:0]  next_code = 8'h3C;

    logic [7:0] exp_q[$];

    task automatic push_exp(input logic [7:0] c);
        exp_q.push_back(c);
    endtask

    always @(negedge cs_n_o) if (mdl_en) begin
        if (last_cs_rise != 0 && ($time - last_cs_rise) < 2*DIV*TCLK) gap_viol++;
        falls    = 0;
        frame_ok = !adc_down && ($time - wake_t >= 800);
        word     = frame_ok ? {1'b0, next_code, 7'b1010101} : 16'h5A5A;
        sdata_i  = word[15];
    end

    always @(negedge sclk_o) if (mdl_en && !cs_n_o) begin
        if (falls > 0 && ($time - last_fall) != 2*DIV*TCLK) per_viol++;
        last_fall = $time;
        falls++;
        #1;
        if (falls < 16) sdata_i = word[15 - falls];
    end

    always @(posedge cs_n_o) if (mdl_en) begin
        last_cs_rise = $time;
        if (falls >= 2 && falls <= 9) begin
            adc_down = 1;
            last_pd_falls = falls;
        end else if (falls >= 11) begin
            if (adc_down) begin
                adc_down = 0;
                wake_t = $time;
                wake_cnt++;
                last_wake_falls = falls;
            end else begin
                if (falls != 16) conv_bad++;
                if (!frame_ok) warm_viol++;
                else begin
                    push_exp(next_code);
                    next_code = next_code + 8'd17;
                end
            end
        end else begin
            bad_window++;
        end
    end

    // ---------------- monitor ----------------
    int  n_valid = 0;
    bit  first_pend = 0;
    time t_start = 0;
    time lat = 0;

    always @(negedge clk) if (!rst && dout_valid_o) begin
        n_valid++;
        if (first_pend) begin
            lat = $time - t_start;
            first_pend = 0;
        end
        if (exp_q.size() == 0) begin
            chk(0, "R4", "valid with no valid frame", dout_o, 0);
        end else begin
            logic [7:0] e;
            e = exp_q.pop_front();
            chk(dout_o == e, "R6", "result data", dout_o, e);
        end
    end

    // ---------------- driver ----------------
    task automatic run(input int n);
        @(negedge clk);
        num_samples_i = CNT_W'(n);
        start_i = 1'b1;
        t_start = $time;
        first_pend = 1;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    task automatic pulse_start();
        @(negedge clk); start_i = 1'b1;
        @(negedge clk); start_i = 1'b0;
    endtask

    task automatic pulse_stop();
        @(negedge clk); stop_i = 1'b1;
        @(negedge clk); stop_i = 1'b0;
    endtask

    task automatic wait_idle();
        while (busy_o) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(150000 * TCLK);
        chk(0, "WATCHDOG", "run did not complete", 0, 1);
        finish_run();
    end

    initial begin
        int base;
        time lat1, lat2, lat3;
        repeat (2) @(negedge clk);
        mdl_en = 1;
        repeat (8) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(busy_o == 1'b1, "R1", "busy after reset", busy_o, 1);
        chk(busy_o == 1'b1, "R10", "busy in power-down frame", busy_o, 1);
        wait_idle();
        chk(cs_n_o == 1'b1 && sclk_o == 1'b1, "R1", "idle pins", {cs_n_o, sclk_o}, 3);
        chk(last_pd_falls == 3, "R2", "power-down falls", last_pd_falls, 3);
        chk(adc_down == 1'b1, "R2", "converter asleep", adc_down, 1);

        // limited run
        base = n_valid;
        run(5);
        wait (wake_cnt == 1);
        repeat (20) @(negedge clk);
        chk(busy_o == 1'b1, "R10", "busy during warm-up", busy_o, 1);
        chk(n_valid == base, "R4", "no result in warm-up", n_valid - base, 0);
        wait_idle();
        lat1 = lat;
        chk(n_valid - base == 5, "R7", "results in counted run", n_valid - base, 5);
        chk(last_wake_falls == 16, "R3", "wake frame falls", last_wake_falls, 16);
        chk(adc_down == 1'b1 && last_pd_falls == 3, "R2", "asleep after run", last_pd_falls, 3);
        chk(exp_q.size() == 0, "R6", "scoreboard drained", exp_q.size(), 0);

        // start while running is ignored
        base = n_valid;
        run(3);
        wait (n_valid == base + 1);
        pulse_start();
        wait_idle();
        lat2 = lat;
        chk(n_valid - base == 3, "R9", "count unchanged by late start", n_valid - base, 3);
        chk(wake_cnt == 2, "R9", "no extra wake", wake_cnt, 2);
        chk(lat2 == lat1, "R11", "first-result latency run 2", lat2, lat1);

        // unlimited run with stop during conversion
        base = n_valid;
        run(0);
        wait (n_valid == base + 4);
        pulse_stop();
        wait_idle();
        lat3 = lat;
        chk(n_valid - base == 5, "R8", "stop lets frame finish", n_valid - base, 5);
        chk(n_valid - base > 4, "R7", "zero count keeps running", n_valid - base, 5);
        chk(lat3 == lat1, "R11", "first-result latency run 3", lat3, lat1);

        // stop during warm-up
        base = n_valid;
        run(0);
        wait (wake_cnt == 4);
        repeat (20) @(negedge clk);
        pulse_stop();
        wait_idle();
        chk(n_valid == base, "R8", "stop in warm-up gives no result", n_valid - base, 0);
        chk(adc_down == 1'b1, "R8", "asleep after warm-up stop", adc_down, 1);

        repeat (10) @(negedge clk);
        chk(bad_window == 0, "R2", "CS edges outside allowed window", bad_window, 0);
        chk(warm_viol == 0, "R4", "frames inside warm-up", warm_viol, 0);
        chk(per_viol == 0, "R5", "sclk period errors", per_viol, 0);
        chk(gap_viol == 0, "R5", "short CS-high gaps", gap_viol, 0);
        chk(conv_bad == 0, "R5", "conversion frames not 16 falls", conv_bad, 0);
        chk(exp_q.size() == 0, "R6", "scoreboard drained at end", exp_q.size(), 0);
        finish_run();
    end

endmodule